// File: doc/BRIEF.md
# Single-Wire ROM Command and Identity Responder

This block is the network-layer front end of a single-wire slave device. A bit-level layer handles the slot timing and reports three kinds of event: a bus reset with presence, a bit written by the master, and a read slot opened by the master. After each bus reset the block collects one ROM command byte, least significant bit first. It then does one of three things: it sends its 64-bit identity, it compares a 64-bit identity sent by the master, or it grants access straight away. When a command succeeds, the block raises a memory-enable output that hands the bus to the memory-function layer. That output stays high until the next bus reset.

The identity is a design parameter holding three fields. The family code is in bits 7:0, the serial number in bits 55:8 and the CRC byte in bits 63:56. Bits travel on the wire from bit 0 upward. After each device reset, a bit-serial CRC-8 shift register (polynomial x^8 + x^5 + x^4 + 1) runs over all 64 stored bits. It flags whether the residue is zero, which shows that the stored CRC byte agrees with the other 56 bits.

Top module: `ow_rom_responder`

## Requirements
- R1: While `rst_n` is low and afterwards until the first `bus_reset`, `mem_en` and `tx_active` are 0, `tx_bit` is 1, and received bits and read requests have no effect.
- R2: After a `bus_reset` pulse the block takes the next 8 `rx_valid` bits as the command byte, first bit into bit 0.
- R3: Command 33h starts transmission. `tx_active` goes to 1 and `tx_bit` presents identity bit k before the (k+1)-th `tx_req`, for k from 0 to 63. One cycle after the 64th `tx_req`, `mem_en` becomes 1 and `tx_active` becomes 0.
- R4: Command CCh sets `mem_en` to 1 one cycle after the eighth command bit.
- R5: Command 55h compares the next 64 received bits with identity bits 0 to 63 in order. If all match, `mem_en` becomes 1 one cycle after the 64th bit.
- R6: During a 55h compare, the first received bit that differs from the identity puts the block in idle. `mem_en` then stays 0 for all later bits until the next `bus_reset`.
- R7: Any command byte other than 33h, CCh and 55h puts the block in idle. Later bits and read requests leave `mem_en` at 0 and `tx_active` at 0 until the next `bus_reset`. After that reset, commands are accepted normally again.
- R8: A `bus_reset` pulse in any state clears `mem_en` and `tx_active` in the next cycle and restarts command reception from bit 0, even in the middle of a byte.
- R9: `id_check_done` rises 64 cycles after reset is released and then stays high. From that point, `id_crc_ok` is 1 exactly when the CRC-8 residue of all 64 identity bits is zero.
- R10: Outside Read ROM transmission, `tx_active` is 0, `tx_bit` is 1 (released line), and `tx_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: the bus saw a reset and presence sequence |
| rx_valid | input | 1 | One-cycle pulse: a master-written bit is available |
| rx_bit | input | 1 | Value of the master-written bit |
| tx_req | input | 1 | One-cycle pulse: a read slot consumes the current `tx_bit` |
| tx_bit | output | 1 | Bit the slave drives in the current read slot |
| tx_active | output | 1 | High while the identity is being sent |
| mem_en | output | 1 | Access granted to the memory-function layer |
| id_check_done | output | 1 | Identity self-check finished |
| id_crc_ok | output | 1 | Identity CRC residue is zero |

## Verification
The bench builds the block at its full 8-bit command width and 64-bit identity. It uses an identity whose CRC byte the bench derives by byte-wise division, plus a second copy with one CRC bit flipped. The 8-bit command space is small, so the bench sends every one of the 256 command values after a fresh bus reset and follows each one to its end. The 64-bit identity makes a sweep of a single mismatched bit at every compare position cheap as well, so the early-exit path of the compare is covered at each index.

// File: rtl/ow_rom_pkg.sv
// Package: shared types and default codes for the ROM command responder.
// Assumes the command byte is 8 bits wide; codes may be overridden by parameters.
package ow_rom_pkg;

    // Network-layer states of the responder
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a bus reset; everything ignored
        ST_CMD   = 3'd1,   // collecting the command byte
        ST_READ  = 3'd2,   // sending the identity
        ST_MATCH = 3'd3,   // comparing the master's identity
        ST_MEM   = 3'd4    // memory layer granted
    } rom_state_t;

    localparam logic [7:0] CMD_READ_DEF  = 8'h33;
    localparam logic [7:0] CMD_SKIP_DEF  = 8'hCC;
    localparam logic [7:0] CMD_MATCH_DEF = 8'h55;

    // Reflected form of x^8 + x^5 + x^4 + 1
    localparam logic [7:0] CRC8_POLY_REFL = 8'h8C;

endpackage

// File: rtl/crc8_serial.sv
// Module: bit-serial reflected CRC shift register.
// Shifts one bit per enabled cycle, LSB-first data. Assumes the register is
// cleared by reset before a new computation starts.
module crc8_serial #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    POLY = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic         fb;
    logic [W-1:0] crc_nxt;

    assign fb = crc[0] ^ din;

    // One stage per register bit: shift toward bit 0, fold in feedback at taps
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_top
            assign crc_nxt[i] = fb & POLY[i];
        end else begin : g_mid
            assign crc_nxt[i] = crc[i+1] ^ (fb & POLY[i]);
        end
    end

    // Register update: clear on reset, shift when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)  crc <= '0;
        else if (en) crc <= crc_nxt;
    end

endmodule

// File: rtl/id_crc_check.sv
// Module: identity self-check sequencer.
// After reset it feeds all ID_W identity bits, bit 0 first, one per cycle
// into a serial CRC register, then reports done and whether the residue is 0.
// Assumes the identity is a constant for the life of the device.
module id_crc_check
    import ow_rom_pkg::*;
#(
    parameter int                ID_W = 64,
    parameter logic [ID_W-1:0]   ID   = '0
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output logic ok
);

    localparam int CNT_W = $clog2(ID_W);
    localparam int IDX_W = CNT_W + 1;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(ID_W);

    logic [IDX_W-1:0] idx;
    logic [7:0]       residue;
    logic             feed;

    assign feed = (idx != IDX_END);
    assign done = !feed;
    assign ok   = done && (residue == 8'h00);

    // Bit pointer: walks the identity once after reset, then parks
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (feed) idx <= idx + 1'b1;
    end

    crc8_serial #(
        .W    (8),
        .POLY (CRC8_POLY_REFL)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (feed),
        .din   (ID[idx[CNT_W-1:0]]),
        .crc   (residue)
    );

    // R9
    check_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(ok)));

endmodule

// File: rtl/rom_cmd_ctrl.sv
// Module: ROM command state machine.
// Collects the command byte after each bus reset and then sends the identity,
// compares a received identity, or grants memory access. Assumes the bit layer
// gives at most one of rx_valid / tx_req per cycle and single-cycle pulses.
module rom_cmd_ctrl
    import ow_rom_pkg::*;
#(
    parameter int                ID_W      = 64,
    parameter int                CMD_W     = 8,
    parameter logic [ID_W-1:0]   ID        = '0,
    parameter logic [CMD_W-1:0]  CMD_READ  = CMD_READ_DEF,
    parameter logic [CMD_W-1:0]  CMD_SKIP  = CMD_SKIP_DEF,
    parameter logic [CMD_W-1:0]  CMD_MATCH = CMD_MATCH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic tx_req,
    output logic tx_bit,
    output logic tx_active,
    output logic mem_en
);

    localparam int CNT_W  = $clog2(ID_W);
    localparam int CCNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0]  LAST_ID  = CNT_W'(ID_W - 1);
    localparam logic [CCNT_W-1:0] LAST_CMD = CCNT_W'(CMD_W - 1);

    rom_state_t        state;
    logic [CNT_W-1:0]  bit_idx;
    logic [CCNT_W-1:0] cmd_idx;
    logic [CMD_W-1:0]  cmd_sr;
    logic [CMD_W-1:0]  cmd_full;
    logic              id_bit;

    assign cmd_full  = {rx_bit, cmd_sr[CMD_W-1:1]};
    assign id_bit    = ID[bit_idx];
    assign tx_active = (state == ST_READ);
    assign tx_bit    = (state == ST_READ) ? id_bit : 1'b1;
    assign mem_en    = (state == ST_MEM);

    // State, counters and command shifter; bus reset overrides everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            cmd_idx <= '0;
            cmd_sr  <= '0;
        end else if (bus_reset) begin
            state   <= ST_CMD;
            bit_idx <= '0;
            cmd_idx <= '0;
            cmd_sr  <= '0;
        end else begin
            case (state)
                ST_CMD: if (rx_valid) begin
                    cmd_sr  <= cmd_full;
                    cmd_idx <= cmd_idx + 1'b1;
                    if (cmd_idx == LAST_CMD) begin
                        bit_idx <= '0;
                        if      (cmd_full == CMD_READ)  state <= ST_READ;
                        else if (cmd_full == CMD_SKIP)  state <= ST_MEM;
                        else if (cmd_full == CMD_MATCH) state <= ST_MATCH;
                        else                            state <= ST_IDLE;
                    end
                end
                ST_READ: if (tx_req) begin
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == LAST_ID) state <= ST_MEM;
                end
                ST_MATCH: if (rx_valid) begin
                    bit_idx <= bit_idx + 1'b1;
                    if (rx_bit != id_bit)       state <= ST_IDLE;
                    else if (bit_idx == LAST_ID) state <= ST_MEM;
                end
                default: ;
            endcase
        end
    end

    // R8
    busrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!mem_en && !tx_active));

    // R3
    grant_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en) |-> $past(rx_valid || tx_req));

    // R6
    mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MATCH && rx_valid && !bus_reset && (rx_bit != id_bit))
            |=> (!mem_en && !tx_active));

    // R3
    txbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !tx_req && !bus_reset) |=> $stable(tx_bit));

    // R10
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !bus_reset && tx_req) |=> !tx_active);

endmodule

// File: rtl/ow_rom_responder.sv
// Module: top of the single-wire ROM command and identity responder.
// Joins the command state machine and the identity self-check. Assumes an
// external bit layer provides reset, write-bit and read-slot pulses.
module ow_rom_responder
    import ow_rom_pkg::*;
#(
    parameter int                ID_W      = 64,
    parameter int                CMD_W     = 8,
    parameter logic [ID_W-1:0]   ID        = 64'hA200_0000_01B8_1C02,
    parameter logic [CMD_W-1:0]  CMD_READ  = CMD_READ_DEF,
    parameter logic [CMD_W-1:0]  CMD_SKIP  = CMD_SKIP_DEF,
    parameter logic [CMD_W-1:0]  CMD_MATCH = CMD_MATCH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic tx_req,
    output logic tx_bit,
    output logic tx_active,
    output logic mem_en,
    output logic id_check_done,
    output logic id_crc_ok
);

    rom_cmd_ctrl #(
        .ID_W      (ID_W),
        .CMD_W     (CMD_W),
        .ID        (ID),
        .CMD_READ  (CMD_READ),
        .CMD_SKIP  (CMD_SKIP),
        .CMD_MATCH (CMD_MATCH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .tx_req    (tx_req),
        .tx_bit    (tx_bit),
        .tx_active (tx_active),
        .mem_en    (mem_en)
    );

    id_crc_check #(
        .ID_W (ID_W),
        .ID   (ID)
    ) u_idchk (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (id_check_done),
        .ok    (id_crc_ok)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_en && !tx_active));

endmodule

// File: tb/tb_ow_rom_responder.sv
`timescale 1ns/1ps
module tb_ow_rom_responder;

    // Byte-wise CRC-8, reflected polynomial, independent of the serial RTL form
    function automatic logic [7:0] crc_of(input logic [55:0] d);
        logic [7:0] c;
        c = 8'h00;
        for (int k = 0; k < 7; k++) begin
            c = c ^ d[8*k +: 8];
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
        end
        return c;
    endfunction

    localparam logic [55:0] BODY   = {48'h00A1B2C3D4E5, 8'h23};
    localparam logic [63:0] ID_OK  = {crc_of(BODY), BODY};
    localparam logic [63:0] ID_BAD = ID_OK ^ (64'd1 << 60);

    logic clk = 0, rst_n = 0;
    logic bus_reset = 0, rx_valid = 0, rx_bit = 0, tx_req = 0;
    logic tx_bit, tx_active, mem_en, done_g, ok_g;
    logic tx_bit_b, tx_active_b, mem_en_b, done_b, ok_b;
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ow_rom_responder #(.ID(ID_OK)) dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .tx_active(tx_active),
        .mem_en(mem_en), .id_check_done(done_g), .id_crc_ok(ok_g));

    ow_rom_responder #(.ID(ID_BAD)) dut_bad (
        .clk(clk), .rst_n(rst_n), .bus_reset(1'b0), .rx_valid(1'b0),
        .rx_bit(1'b0), .tx_req(1'b0), .tx_bit(tx_bit_b), .tx_active(tx_active_b),
        .mem_en(mem_en_b), .id_check_done(done_b), .id_crc_ok(ok_b));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_busrst();
        bus_reset = 1; @(negedge clk); bus_reset = 0;
    endtask

    task automatic send_bit(input logic b);
        rx_valid = 1; rx_bit = b; @(negedge clk); rx_valid = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_id(input logic [63:0] v);
        for (int i = 0; i < 64; i++) send_bit(v[i]);
    endtask

    task automatic read_bit(output logic b);
        b = tx_bit; tx_req = 1; @(negedge clk); tx_req = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

    initial begin
        logic [63:0] got;
        logic b;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset mem_en", {63'd0, mem_en}, 64'd0);
        check("R1 reset tx", {62'd0, tx_active, tx_bit}, 64'd1);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R9: not finished early
        check("R9 early done", {63'd0, done_g}, 64'd0);
        // R1: bits before the first bus reset are ignored
        send_byte(8'hCC);
        read_bit(b);
        check("R1 pre-busreset ignored", {62'd0, mem_en, tx_active}, 64'd0);
        repeat (60) @(negedge clk);
        // R9: self-check results
        check("R9 good done/ok", {62'd0, done_g, ok_g}, 64'd3);
        check("R9 bad done/ok", {62'd0, done_b, ok_b}, 64'd2);

        // R2/R3/R4/R5/R7: every command byte
        for (int c = 0; c < 256; c++) begin
            pulse_busrst();
            check("R8 cleared after busreset", {63'd0, mem_en}, 64'd0);
            send_byte(8'(c));
            if (c == 8'h33) begin
                check("R3 tx_active", {63'd0, tx_active}, 64'd1);
                for (int i = 0; i < 64; i++) begin
                    read_bit(b);
                    got[i] = b;
                end
                check("R3 identity bits", got, ID_OK);
                check("R3 grant", {62'd0, mem_en, tx_active}, 64'd2);
            end else if (c == 8'hCC) begin
                check("R4 skip grant", {63'd0, mem_en}, 64'd1);
                read_bit(b);
                // R10: released line in memory state
                check("R10 tx released", {61'd0, b, tx_active, mem_en}, 64'd5);
            end else if (c == 8'h55) begin
                check("R5 waiting", {62'd0, mem_en, tx_active}, 64'd0);
                read_bit(b);
                check("R10 tx during match", {62'd0, b, tx_active}, 64'd2);
                send_id(ID_OK);
                check("R5 match grant", {63'd0, mem_en}, 64'd1);
            end else begin
                // R2: byte order decides; everything else idles
                send_id(ID_OK);
                read_bit(b);
                check("R7 unknown idles", {61'd0, mem_en, tx_active, b}, 64'd1);
            end
        end

        // R6: single mismatch at each compare position
        for (int p = 0; p < 64; p++) begin
            pulse_busrst();
            send_byte(8'h55);
            send_id(ID_OK ^ (64'd1 << p));
            check("R6 mismatch no grant", {63'd0, mem_en}, 64'd0);
        end
        // R7: recovery after idle
        pulse_busrst();
        send_byte(8'hCC);
        check("R7 recovery", {63'd0, mem_en}, 64'd1);

        // R8: bus reset in the middle of a command byte
        pulse_busrst();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        pulse_busrst();
        send_byte(8'hCC);
        check("R8 mid-byte restart", {63'd0, mem_en}, 64'd1);
        // R8: bus reset in the middle of a read
        pulse_busrst();
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) read_bit(b);
        pulse_busrst();
        check("R8 mid-read clear", {62'd0, mem_en, tx_active}, 64'd0);
        // R8: bus reset while granted
        send_byte(8'hCC);
        pulse_busrst();
        check("R8 clear grant", {63'd0, mem_en}, 64'd0);

        finished = 1;
        finish_run();
    end

endmodule